// File: doc/BRIEF.md
# ADC Offset Calibration Sequencer

This block sits behind the decimation stage of a two-channel 24-bit audio converter and removes its DC offset. When the enable input `run` goes high, a calibration window opens. The window lasts a fixed number of frame strobes, and that number depends on the speed mode and on whether the serial port is clock master or slave. During the window the block measures a reference on each channel and averages it. A select output tells the analog front end which reference to route: the common-mode voltage or the real inputs.

When the window closes, the block keeps one averaged offset per channel. After a further settling count of frames it declares the output valid. From then on, each incoming sample has its channel's offset subtracted, and the result is clamped to the 24-bit two's-complement range. While `run` is low, the block is idle and every output it drives is held at zero. Dropping `run` and raising it again starts a fresh calibration from nothing.

Top module: `ocal_seq`

## Requirements
- R1: While `run` is low, at every clock edge the block returns to idle. From the edge after `run` was sampled low, `busy`, `ref_sel`, `out_valid`, `out_l` and `out_r` are all 0.
- R2: At the first clock edge where `run` is sampled high after idle, `busy` goes to 1. At that same edge the block captures `dbl_speed` and `slave_mode` for the whole cycle. Later changes to either input have no effect until the next idle.
- R3: The block counts the frame strobes it samples while `busy` is 1. `busy` falls at the edge that samples strobe number N. N is 8704 when `dbl_speed`=0 and 17408 when `dbl_speed`=1, plus 1 when `slave_mode`=1.
- R4: `out_valid` rises at the edge that samples counted strobe number M. M is 8960 when `dbl_speed`=0 and 17920 when `dbl_speed`=1, plus 1 when `slave_mode`=1. Whenever `out_valid` is 0, `out_l` and `out_r` are 0.
- R5: While `busy` is 1, `ref_sel` equals `zcal` (0 = common-mode reference, 1 = analog inputs). While `run` is high after `busy` has fallen, `ref_sel` is 1.
- R6: Each channel's offset is the sum of its samples at the last 4096 counted strobes of the window, arithmetically shifted right by 12. This rounds toward minus infinity. Samples at earlier strobes of the window do not contribute.
- R7: While `out_valid` is 1, each strobe registers `sample - offset` on that channel's output, visible after that edge. With no strobe, the outputs hold their value.
- R8: The subtraction saturates: results above 8388607 give 0x7FFFFF, and results below -8388608 give 0x800000. The exact limits pass through unclamped.
- R9: A fall and a new rise of `run` during calibration clears the strobe count and both accumulators. The new window is timed and averaged as if the block had just come out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; a rising edge starts calibration, low holds the block idle |
| dbl_speed | input | 1 | 1 selects double-rate frame timing |
| slave_mode | input | 1 | 1 when the serial port is clock slave (one extra frame) |
| zcal | input | 1 | Reference choice for calibration: 0 common-mode, 1 analog inputs |
| frame_stb | input | 1 | One-cycle strobe per frame, samples valid with it |
| smp_l | input | 24 | Left sample, two's complement |
| smp_r | input | 24 | Right sample, two's complement |
| busy | output | 1 | Calibration window in progress |
| ref_sel | output | 1 | Front-end reference select |
| out_valid | output | 1 | Corrected data valid |
| out_l | output | 24 | Corrected left sample |
| out_r | output | 24 | Corrected right sample |

## Verification
The hardest situations to reach from the ports are the ones that sit thousands of frames after the rising edge of `run`. These are the boundary where averaging starts and the exact strobes that end `busy` and start `out_valid`. The slave and double-speed offsets make each of these strobes different. The bench therefore drives a strobe on every clock and keeps its own frame count. It feeds a deliberately different value before the averaging window, so that an off-by-one window start changes the offset. It checks the two status edges one strobe before and at their expected count. It uses alternating window samples with a half-LSB average, so the floor rounding of negative and positive offsets shows up in the corrected data. Last, it aborts a half-finished window to prove that stale accumulation does not survive a restart.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
    parameter int SMP_W    = 24;
    parameter int AVG_LOG2 = 12;
    parameter int ACC_W    = SMP_W + AVG_LOG2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CAL    = 2'd1,
        ST_SETTLE = 2'd2,
        ST_LIVE   = 2'd3
    } seq_st_e;

    typedef logic signed [SMP_W-1:0] smp_t;

    function automatic smp_t sat_sub(input smp_t a, input smp_t b);
        logic signed [SMP_W:0] d;
        logic signed [SMP_W:0] hi;
        logic signed [SMP_W:0] lo;
        d  = (SMP_W+1)'(a) - (SMP_W+1)'(b);
        hi = (SMP_W+1)'({1'b0, {(SMP_W-1){1'b1}}});
        lo = (SMP_W+1)'({2'b11, {(SMP_W-1){1'b0}}});
        if (d > hi)      return {1'b0, {(SMP_W-1){1'b1}}};
        else if (d < lo) return {1'b1, {(SMP_W-1){1'b0}}};
        else             return d[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/ocal_timer.sv
module ocal_timer
    import ocal_pkg::*;
#(
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    dbl_speed,
    input  logic    slave_mode,
    input  logic    frame_stb,
    output seq_st_e state,
    output logic    acc_en,
    output logic    latch_off,
    output logic    live_upd
);
    localparam int CW  = $clog2(2 * VALID_FRAMES + 2);
    localparam int WIN = 1 << AVG_LOG2;

    logic [CW-1:0] cnt, cal_len, valid_len, win_start, cnt_inc;
    logic          dbl_m, slave_m;

    always_comb begin
        cal_len   = (CW'(CAL_FRAMES) << dbl_m) + CW'(slave_m);
        valid_len = (CW'(VALID_FRAMES) << dbl_m) + CW'(slave_m);
        win_start = cal_len - CW'(WIN);
        cnt_inc   = cnt + CW'(1);
    end

    assign acc_en    = (state == ST_CAL) && frame_stb && (cnt >= win_start);
    assign latch_off = (state == ST_CAL) && frame_stb && (cnt_inc == cal_len);
    assign live_upd  = (state == ST_LIVE) && frame_stb;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            dbl_m   <= 1'b0;
            slave_m <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state   <= ST_CAL;
                    cnt     <= '0;
                    dbl_m   <= dbl_speed;
                    slave_m <= slave_mode;
                end
                ST_CAL: if (frame_stb) begin
                    cnt <= cnt_inc;
                    if (cnt_inc == cal_len) state <= ST_SETTLE;
                end
                ST_SETTLE: if (frame_stb) begin
                    cnt <= cnt_inc;
                    if (cnt_inc == valid_len) state <= ST_LIVE;
                end
                default: state <= ST_LIVE;
            endcase
        end
    end
endmodule

// File: rtl/ocal_chan.sv
module ocal_chan
    import ocal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic acc_en,
    input  logic latch_off,
    input  logic live,
    input  logic live_upd,
    input  smp_t sample,
    output smp_t dout
);
    logic signed [ACC_W-1:0] acc, acc_nx;
    smp_t                    offset;

    assign acc_nx = acc + ACC_W'(sample);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc    <= '0;
            offset <= '0;
        end else begin
            if (acc_en)    acc    <= acc_nx;
            if (latch_off) offset <= SMP_W'(acc_nx >>> AVG_LOG2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || !live) dout <= '0;
        else if (live_upd)       dout <= sat_sub(sample, offset);
    end
endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
    import ocal_pkg::*;
#(
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960,
    parameter int N_CH         = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             dbl_speed,
    input  logic             slave_mode,
    input  logic             zcal,
    input  logic             frame_stb,
    input  logic [SMP_W-1:0] smp_l,
    input  logic [SMP_W-1:0] smp_r,
    output logic             busy,
    output logic             ref_sel,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_l,
    output logic [SMP_W-1:0] out_r
);
    seq_st_e state;
    logic    acc_en, latch_off, live_upd, clr, live;
    smp_t    smp_v [N_CH];
    smp_t    out_v [N_CH];

    ocal_timer #(.CAL_FRAMES(CAL_FRAMES), .VALID_FRAMES(VALID_FRAMES)) u_timer (
        .clk(clk), .rst(rst), .run(run), .dbl_speed(dbl_speed),
        .slave_mode(slave_mode), .frame_stb(frame_stb), .state(state),
        .acc_en(acc_en), .latch_off(latch_off), .live_upd(live_upd)
    );

    assign clr  = !run || (state == ST_IDLE);
    assign live = run && (state == ST_LIVE);

    assign smp_v[0] = smp_l;
    assign smp_v[1] = smp_r;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ocal_chan u_chan (
            .clk(clk), .rst(rst), .clr(clr), .acc_en(acc_en),
            .latch_off(latch_off), .live(live), .live_upd(live_upd),
            .sample(smp_v[c]), .dout(out_v[c])
        );
    end

    assign out_l = out_v[0];
    assign out_r = out_v[1];

    assign busy      = (state == ST_CAL);
    assign out_valid = (state == ST_LIVE);

    always_comb begin
        unique case (state)
            ST_IDLE: ref_sel = 1'b0;
            ST_CAL:  ref_sel = zcal;
            default: ref_sel = 1'b1;
        endcase
    end
endmodule

// File: rtl/ocal_seq_chk.sv
module ocal_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        frame_stb,
    input logic        zcal,
    input logic        busy,
    input logic        ref_sel,
    input logic        out_valid,
    input logic [23:0] out_l,
    input logic [23:0] out_r
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!busy && !ref_sel && !out_valid && out_l == 24'd0 && out_r == 24'd0));

    p_busy_start_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !$past(run) && !$past(rst)) |=> busy);

    p_busy_end_on_stb_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && run) |-> $past(frame_stb));

    p_valid_rise_on_stb_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(frame_stb) && !$past(busy) && !busy));

    p_muted_when_invalid_r4: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_l == 24'd0 && out_r == 24'd0));

    p_ref_follows_zcal_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ref_sel == zcal));

    p_hold_without_stb_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !$past(frame_stb)) |-> ($stable(out_l) && $stable(out_r)));
endmodule

bind ocal_seq ocal_seq_chk u_chk (
    .clk(clk), .rst(rst), .run(run), .frame_stb(frame_stb), .zcal(zcal),
    .busy(busy), .ref_sel(ref_sel), .out_valid(out_valid),
    .out_l(out_l), .out_r(out_r)
);

// File: tb/tb_ocal_seq.sv
module tb_ocal_seq;
    logic        clk = 1'b0;
    logic        rst, run, dbl_speed, slave_mode, zcal, frame_stb;
    logic [23:0] smp_l, smp_r;
    logic        busy, ref_sel, out_valid;
    logic [23:0] out_l, out_r;

    int     n_chk = 0;
    int     n_bad = 0;
    longint offl, offr;

    // left, right pairs applied once outputs are live
    localparam logic [47:0] VEC [6] = '{
        {24'h000000, 24'h000000},
        {24'h7FFFFF, 24'h800000},
        {24'h7FFC17, 24'h801388},
        {24'h7FFC18, 24'h801387},
        {24'hFFFC18, 24'h001388},
        {24'h123456, 24'hABCDEF}
    };

    always #10 clk = ~clk;

    ocal_seq dut (
        .clk(clk), .rst(rst), .run(run), .dbl_speed(dbl_speed),
        .slave_mode(slave_mode), .zcal(zcal), .frame_stb(frame_stb),
        .smp_l(smp_l), .smp_r(smp_r), .busy(busy), .ref_sel(ref_sel),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [23:0] bsat(input longint v);
        if (v > 64'sd8388607)  return 24'h7FFFFF;
        if (v < -64'sd8388608) return 24'h800000;
        return v[23:0];
    endfunction

    task automatic step(input logic s, input logic [23:0] l, input logic [23:0] r);
        frame_stb = s; smp_l = l; smp_r = r;
        @(posedge clk); #2;
    endtask

    task automatic calibrate(input logic d, input logic sl, input logic z,
                             input int bl, input int br);
        int     cal_len, val_len;
        longint suml, sumr;
        suml = 0; sumr = 0;
        cal_len = (8704 << d) + int'(sl);
        val_len = (8960 << d) + int'(sl);
        run = 1'b0; dbl_speed = d; slave_mode = sl; zcal = z;
        step(1'b1, 24'h111111, 24'h222222);
        chk(!busy && !out_valid && !ref_sel && out_l == 0 && out_r == 0, "R1 idle outputs",
            {busy, out_valid, ref_sel, (out_l | out_r) != 0}, 0);
        step(1'b0, 24'h0, 24'h0);
        run = 1'b1;
        step(1'b0, 24'h0, 24'h0);
        chk(busy == 1'b1, "R2 busy on start", busy, 1);
        chk(ref_sel == z, "R5 ref_sel follows zcal", ref_sel, z);
        dbl_speed = ~d; slave_mode = ~sl;  // R2: must be ignored now
        for (int n = 1; n <= val_len; n++) begin
            int l, r;
            if (n <= cal_len - 4096) begin l = 4000000; r = -3000000; end
            else if (n <= cal_len) begin l = bl + (n & 1); r = br + (n & 1); end
            else begin l = 777; r = -777; end
            if (n > cal_len - 4096 && n <= cal_len) begin suml += l; sumr += r; end
            step(1'b1, 24'(l), 24'(r));
            if (n == cal_len - 1) chk(busy == 1'b1, "R3 busy before count", busy, 1);
            if (n == cal_len) begin
                chk(busy == 1'b0, "R3 busy falls at count", busy, 0);
                chk(ref_sel == 1'b1, "R5 ref_sel after window", ref_sel, 1);
            end
            if (n == val_len - 1) begin
                chk(out_valid == 1'b0, "R4 valid before count", out_valid, 0);
                chk(out_l == 0 && out_r == 0, "R4 muted before valid", out_l, 0);
            end
            if (n == val_len) begin
                chk(out_valid == 1'b1, "R4 valid at count", out_valid, 1);
                chk(out_l == 0, "R4 muted until next strobe", out_l, 0);
            end
        end
        offl = suml >>> 12;
        offr = sumr >>> 12;
        dbl_speed = d; slave_mode = sl;
    endtask

    task automatic walk();
        foreach (VEC[i]) begin
            longint vl, vr;
            logic [23:0] el, er;
            vl = longint'($signed(VEC[i][47:24]));
            vr = longint'($signed(VEC[i][23:0]));
            el = bsat(vl - offl);
            er = bsat(vr - offr);
            step(1'b1, VEC[i][47:24], VEC[i][23:0]);
            chk(out_l == el, "R6 R7 R8 left corrected", $signed(out_l), $signed(el));
            chk(out_r == er, "R6 R7 R8 right corrected", $signed(out_r), $signed(er));
            step(1'b0, 24'h055555, 24'h066666);
            chk(out_l == el && out_r == er, "R7 hold without strobe", $signed(out_l), $signed(el));
        end
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog: run incomplete, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b0; dbl_speed = 1'b0; slave_mode = 1'b0; zcal = 1'b0;
        frame_stb = 1'b0; smp_l = '0; smp_r = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        step(1'b0, 24'h0, 24'h0);
        chk(!busy && !out_valid && out_l == 0 && out_r == 0, "R1 reset state", busy, 0);

        // normal speed, master, common-mode reference
        calibrate(1'b0, 1'b0, 1'b0, -1000, 5000);
        chk(offl == -1000 && offr == 5000, "R6 bench offsets", offl, -1000);
        walk();

        // double speed, slave, analog-input reference
        calibrate(1'b1, 1'b1, 1'b1, 7, -3);
        walk();

        // R9: abort a half-done window, then recalibrate
        run = 1'b0; step(1'b0, 24'h0, 24'h0);
        run = 1'b1; step(1'b0, 24'h0, 24'h0);
        for (int n = 0; n < 5000; n++) step(1'b1, 24'd2000000, -24'sd2000000);
        chk(busy == 1'b1, "R9 still busy mid window", busy, 1);
        calibrate(1'b0, 1'b0, 1'b0, 50, 60);
        chk(offl == 50 && offr == 60, "R9 bench offsets", offl, 50);
        walk();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule